// File: doc/BRIEF.md
# Cascadable Magnitude Comparator Stage

This block compares two unsigned words of `WIDTH` bits (four by default) and reports one of three verdicts: first word greater, words equal, or first word smaller. The verdict is settled by the highest bit position at which the two words disagree. Lower positions never override a higher one.

Three cascade inputs accept the verdict of a less significant stage. They take effect only when the local words match exactly. This lets any number of stages be chained into a wider compare. The lowest stage of a chain has its cascade inputs tied to "equal". Each higher stage takes the three outputs of the stage below it as its cascade inputs.

When the words match, two combinations of the cascade inputs have defined meanings that tree arrangements rely on:
- With the equal input low and both the greater and smaller inputs high, all three outputs go low.
- With all three cascade inputs low, the greater and smaller outputs both go high.

The block is purely combinational.

Top module: `mag_compare_stage`

## Requirements
- R1: When the words differ and the most significant differing bit is 1 in `a_word`, `out_gt`=1 and `out_lt`=0, whatever the cascade inputs.
- R2: When the words differ and the most significant differing bit is 1 in `b_word`, `out_lt`=1 and `out_gt`=0, whatever the cascade inputs.
- R3: When the words differ, `out_eq`=0 and exactly one of `out_gt` and `out_lt` is 1.
- R4: When the words are equal and `cin_eq`=1, the outputs (`out_gt`,`out_eq`,`out_lt`) are (0,1,0), whatever `cin_gt` and `cin_lt` are.
- R5: When the words are equal and the cascade inputs (`cin_gt`,`cin_eq`,`cin_lt`) are (1,0,0), the outputs are (1,0,0).
- R6: When the words are equal and the cascade inputs are (0,0,1), the outputs are (0,0,1).
- R7: When the words are equal and the cascade inputs are (1,0,1), the outputs are (0,0,0).
- R8: When the words are equal and the cascade inputs are (0,0,0), the outputs are (1,0,1).
- R9: Two stages in series give the same verdict as a plain compare of the concatenated 8-bit words. In this chain the lower stage's cascade inputs are tied to (0,1,0) and its outputs drive the upper stage's cascade inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_word | input | WIDTH | First operand, unsigned, bit WIDTH-1 most significant |
| b_word | input | WIDTH | Second operand, unsigned |
| cin_gt | input | 1 | Cascade in: lower stage found first word greater |
| cin_eq | input | 1 | Cascade in: lower stage found words equal |
| cin_lt | input | 1 | Cascade in: lower stage found first word smaller |
| out_gt | output | 1 | First word greater |
| out_eq | output | 1 | Words equal |
| out_lt | output | 1 | First word smaller |

## Verification
Every output is due in the same cycle as its stimulus, with no register in the path. A chain of stages is likewise due with zero cycles of latency.

The bench changes the operands and the cascade inputs on the falling clock edge. It samples the outputs one nanosecond later, well before the next rising edge, so every value it reads has settled.

The expected values come from a whole-word integer compare and a cascade table written in the bench. This is a different form from the bit scan in the RTL.

// File: rtl/mag_cmp_pkg.sv
package mag_cmp_pkg;

  typedef struct packed {
    logic gt;
    logic eq;
    logic lt;
  } verdict_t;

  // Outcome when the local words match: the cascade inputs decide.
  function automatic verdict_t resolve_cascade(input verdict_t cin);
    verdict_t r;
    r.eq = cin.eq;
    r.gt = ~cin.eq & ~cin.lt;
    r.lt = ~cin.eq & ~cin.gt;
    return r;
  endfunction

  // Outcome when the local words differ.
  function automatic verdict_t local_verdict(input logic a_higher);
    verdict_t r;
    r.gt = a_higher;
    r.lt = ~a_higher;
    r.eq = 1'b0;
    return r;
  endfunction

endpackage

// File: rtl/mag_cmp_bit.sv
module mag_cmp_bit (
  input  logic a_bit,
  input  logic b_bit,
  output logic differs,
  output logic a_wins
);
  assign differs = a_bit ^ b_bit;
  assign a_wins  = a_bit & ~b_bit;
endmodule

// File: rtl/mag_cmp_scan.sv
module mag_cmp_scan #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] differs,
  input  logic [WIDTH-1:0] a_wins,
  output logic             any_diff,
  output logic             a_higher
);
  // Walk from the top bit down; the first differing bit decides.
  always_comb begin
    any_diff = 1'b0;
    a_higher = 1'b0;
    for (int i = WIDTH - 1; i >= 0; i--) begin
      if (!any_diff && differs[i]) begin
        any_diff = 1'b1;
        a_higher = a_wins[i];
      end
    end
  end
endmodule

// File: rtl/mag_cmp_merge.sv
module mag_cmp_merge
  import mag_cmp_pkg::*;
(
  input  logic     any_diff,
  input  logic     a_higher,
  input  verdict_t cin,
  output verdict_t vout
);
  always_comb begin
    if (any_diff) vout = local_verdict(a_higher);
    else          vout = resolve_cascade(cin);
  end
endmodule

// File: rtl/mag_compare_stage.sv
module mag_compare_stage
  import mag_cmp_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] a_word,
  input  logic [WIDTH-1:0] b_word,
  input  logic             cin_gt,
  input  logic             cin_eq,
  input  logic             cin_lt,
  output logic             out_gt,
  output logic             out_eq,
  output logic             out_lt
);
  logic [WIDTH-1:0] bit_differs;
  logic [WIDTH-1:0] bit_a_wins;
  logic             words_differ;
  logic             a_is_higher;
  verdict_t         cin_v;
  verdict_t         result_v;

  genvar g;
  generate
    for (g = 0; g < WIDTH; g++) begin : g_bit
      mag_cmp_bit u_bit (
        .a_bit   (a_word[g]),
        .b_bit   (b_word[g]),
        .differs (bit_differs[g]),
        .a_wins  (bit_a_wins[g])
      );
    end
  endgenerate

  mag_cmp_scan #(.WIDTH(WIDTH)) u_scan (
    .differs  (bit_differs),
    .a_wins   (bit_a_wins),
    .any_diff (words_differ),
    .a_higher (a_is_higher)
  );

  assign cin_v = '{gt: cin_gt, eq: cin_eq, lt: cin_lt};

  mag_cmp_merge u_merge (
    .any_diff (words_differ),
    .a_higher (a_is_higher),
    .cin      (cin_v),
    .vout     (result_v)
  );

  assign out_gt = result_v.gt;
  assign out_eq = result_v.eq;
  assign out_lt = result_v.lt;
endmodule

// File: rtl/mag_compare_stage_chk.sv
module mag_compare_stage_chk #(
  parameter int WIDTH = 4
) (
  input logic [WIDTH-1:0] a_word,
  input logic [WIDTH-1:0] b_word,
  input logic             cin_gt,
  input logic             cin_eq,
  input logic             cin_lt,
  input logic             out_gt,
  input logic             out_eq,
  input logic             out_lt,
  input logic             words_differ,
  input logic             a_is_higher
);
  always_comb begin
    if (words_differ && a_is_higher)
      AST_GT_WINS: assert (out_gt && !out_lt) else $error("gt"); // R1
    if (words_differ && !a_is_higher)
      AST_LT_WINS: assert (out_lt && !out_gt) else $error("lt"); // R2
    if (a_word != b_word)
      AST_DIFF_ONEHOT: assert (!out_eq && $countones({out_gt, out_lt}) == 1) else $error("diff"); // R3
    if (a_word == b_word && cin_eq)
      AST_EQ_PASS: assert ({out_gt, out_eq, out_lt} == 3'b010) else $error("eq"); // R4
    if (a_word == b_word && {cin_gt, cin_eq, cin_lt} == 3'b100)
      AST_GT_PASS: assert ({out_gt, out_eq, out_lt} == 3'b100) else $error("gtp"); // R5
    if (a_word == b_word && {cin_gt, cin_eq, cin_lt} == 3'b001)
      AST_LT_PASS: assert ({out_gt, out_eq, out_lt} == 3'b001) else $error("ltp"); // R6
    if (a_word == b_word && {cin_gt, cin_eq, cin_lt} == 3'b101)
      AST_BOTH_HIGH: assert ({out_gt, out_eq, out_lt} == 3'b000) else $error("both"); // R7
    if (a_word == b_word && {cin_gt, cin_eq, cin_lt} == 3'b000)
      AST_ALL_LOW: assert ({out_gt, out_eq, out_lt} == 3'b101) else $error("none"); // R8
  end
endmodule

bind mag_compare_stage mag_compare_stage_chk #(.WIDTH(WIDTH)) u_chk (
  .a_word       (a_word),
  .b_word       (b_word),
  .cin_gt       (cin_gt),
  .cin_eq       (cin_eq),
  .cin_lt       (cin_lt),
  .out_gt       (out_gt),
  .out_eq       (out_eq),
  .out_lt       (out_lt),
  .words_differ (words_differ),
  .a_is_higher  (a_is_higher)
);

// File: tb/mag_compare_stage_test.sv
`timescale 1ns/1ps
module mag_compare_stage_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [3:0] a, b;
  logic       cg, ce, cl;
  logic       og, oe, ol;

  mag_compare_stage #(.WIDTH(4)) uut (
    .a_word(a), .b_word(b), .cin_gt(cg), .cin_eq(ce), .cin_lt(cl),
    .out_gt(og), .out_eq(oe), .out_lt(ol)
  );

  // Two-stage serial chain forming an 8-bit compare (R9)
  logic [7:0] wa, wb;
  logic       mg, me, ml, hg, he, hl;

  mag_compare_stage #(.WIDTH(4)) lo_stage (
    .a_word(wa[3:0]), .b_word(wb[3:0]), .cin_gt(1'b0), .cin_eq(1'b1), .cin_lt(1'b0),
    .out_gt(mg), .out_eq(me), .out_lt(ml)
  );
  mag_compare_stage #(.WIDTH(4)) hi_stage (
    .a_word(wa[7:4]), .b_word(wb[7:4]), .cin_gt(mg), .cin_eq(me), .cin_lt(ml),
    .out_gt(hg), .out_eq(he), .out_lt(hl)
  );

  int  n_run  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  task automatic check(input string req, input logic [2:0] got, input logic [2:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: a=%h b=%h cin=%b%b%b got=%b expected=%b",
               req, a, b, cg, ce, cl, got, exp);
    end
  endtask

  function automatic logic [2:0] ref_cascade(input logic [2:0] c);
    case (c)
      3'b100: return 3'b100;
      3'b001: return 3'b001;
      3'b101: return 3'b000;
      3'b000: return 3'b101;
      default: return 3'b010;
    endcase
  endfunction

  task automatic apply(input logic [3:0] va, input logic [3:0] vb, input logic [2:0] c);
    @(negedge clk);
    a = va; b = vb; {cg, ce, cl} = c;
    #1;
  endtask

  task automatic t_initial;
    apply(4'h0, 4'h0, 3'b010);
    check("R4", {og, oe, ol}, 3'b010);
  endtask

  task automatic t_words_differ;
    for (int i = 0; i < 16; i++)
      for (int j = 0; j < 16; j++)
        for (int c = 0; c < 8; c++) begin
          if (i == j) continue;
          apply(i[3:0], j[3:0], c[2:0]);
          if (i > j) check("R1", {og, oe, ol}, 3'b100);
          else       check("R2", {og, oe, ol}, 3'b001);
          check("R3", {1'b0, oe, og ^ ol}, 3'b001);
        end
  endtask

  task automatic t_equal_cascade;
    for (int i = 0; i < 16; i++)
      for (int c = 0; c < 8; c++) begin
        apply(i[3:0], i[3:0], c[2:0]);
        if (c[1])             check("R4", {og, oe, ol}, ref_cascade(c[2:0]));
        else if (c == 3'b100) check("R5", {og, oe, ol}, ref_cascade(c[2:0]));
        else if (c == 3'b001) check("R6", {og, oe, ol}, ref_cascade(c[2:0]));
        else if (c == 3'b101) check("R7", {og, oe, ol}, ref_cascade(c[2:0]));
        else                  check("R8", {og, oe, ol}, ref_cascade(c[2:0]));
      end
  endtask

  task automatic t_chain;
    logic [7:0] partners [6];
    for (int i = 0; i < 256; i++) begin
      partners[0] = i[7:0];
      partners[1] = i[7:0] ^ 8'h01;
      partners[2] = i[7:0] ^ 8'h10;
      partners[3] = i[7:0] ^ 8'h80;
      partners[4] = i[7:0] + 8'd1;
      partners[5] = 8'd255 - i[7:0];
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        wa = i[7:0]; wb = partners[k];
        #1;
        check("R9", {hg, he, hl},
              (wa > wb) ? 3'b100 : (wa == wb) ? 3'b010 : 3'b001);
      end
    end
  endtask

  initial begin
    a = '0; b = '0; cg = 1'b0; ce = 1'b1; cl = 1'b0;
    wa = '0; wb = '0;
    t_initial();
    t_words_differ();
    t_equal_cascade();
    t_chain();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, got=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule